// File: doc/BRIEF.md
# Translation Table Update Command Engine

This block owns a small translation table and runs management commands against it. A command names a table by a 64-bit identifier and gives a bus address, an argument and a count. The engine runs one of four operations. It can write a single entry, or read a single entry back. It can fill a run of consecutive entries with one value. It can also write a run of entries whose values come from a list held in memory, which it fetches itself through a simple read-request port. Each command ends with a one-cycle completion pulse that carries a success or parameter-error status.

Every entry the engine writes produces a map or unmap event. The event carries the page address, taken relative to the window base, and the translated page address. A consumer that mirrors the table, such as a lookup cache, uses these events to stay coherent.

The bus address is first cut down to its page: the low page bits are dropped. The table index is then the distance from the window base, counted in pages. Multi-entry commands walk one page per entry and halt at the first entry that falls outside the table.

Top module: `xlat_cmd_engine`

## Requirements
- R1: A command is rejected with status 1 (parameter error) when any of bits 63:32 of `cmdTableId` is set, or when bits 31:0 differ from `TABLE_ID`. A rejected command writes no entry and emits no event.
- R2: The low `PAGE_SHIFT` bits of `cmdBusAddr` are cleared before use. The index is (address − `BUS_OFFSET`) >> `PAGE_SHIFT`. An index of `ENTRIES` or more, including an address below the base, gives status 1 and no write for that entry.
- R3: Op code 0 (put) writes `cmdArg` into the indexed entry and returns status 0. `cmdCount` is ignored.
- R4: Op code 1 (get) returns the stored 64-bit entry unchanged on `doneData` with status 0. It writes nothing.
- R5: Op code 2 (fill) rejects a count of zero or a count above `ENTRIES`. Otherwise it writes `cmdArg` into `cmdCount` entries on consecutive pages.
- R6: Op code 3 (list put) rejects a count of zero, a count above `LIST_MAX` (512), and a list address in `cmdArg` whose bits 11:0 are not zero. Entry i is read at list address + 8·i. Byte lane k of `memRdData` (bits 8k+7:8k) holds the byte at address + k. The entry is big-endian, so lane 0 is its most significant byte.
- R7: A fill or list put stops at the first out-of-range entry and returns status 1. Entries written before that point keep their new values.
- R8: Each write gives one `evtValid` pulse. On that pulse, `evtIova` is the page address minus `BUS_OFFSET`, and `evtAddr` is the written value with its low `PAGE_SHIFT` bits cleared. `evtMap` is 1 exactly when bits 1:0 of the value are not both zero.
- R9: Reset clears every entry to zero and leaves `busy`, `doneValid`, `evtValid` and `memReq` low.
- R10: `busy` is high from the cycle after a command is accepted through the `doneValid` cycle. `cmdValid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present; accepted when not busy |
| cmdOp | input | 2 | 0 put, 1 get, 2 fill, 3 list put |
| cmdTableId | input | 64 | Table identifier |
| cmdBusAddr | input | 64 | Bus address of the first entry |
| cmdArg | input | 64 | Entry value (put, fill) or list address (list put) |
| cmdCount | input | CNT_W | Entry count for fill and list put |
| busy | output | 1 | Command in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 1 | 0 success, 1 parameter error |
| doneData | output | 64 | Entry read by a get |
| memReq | output | 1 | List read request, held until answered |
| memAddr | output | 64 | List word address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 64 | Read data, byte lane k = address + k |
| evtValid | output | 1 | Map/unmap event pulse |
| evtMap | output | 1 | 1 map, 0 unmap |
| evtIova | output | 64 | Page address relative to the window base |
| evtAddr | output | 64 | Translated page address |

## Verification
Take the negative edge after the one where the bench drives `cmdValid` as cycle 1. A rejected command and a get complete on cycle 2. A put, or a fill that takes k write steps, completes on cycle 2 + k. A list put whose memory answers one cycle after each request completes on cycle 2 + 2k. The last event pulse falls in the same cycle as `doneValid`. The bench counts negative edges from the command until `doneValid` and compares the count with this latency, computed from its own model. It records event pulses in a monitor and compares them only after a short delay past the completion edge, so the final event is always captured before the comparison.

// File: rtl/xlat_cmd_pkg.sv
package xlat_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_STEP,
    ST_DONE
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new command
    logic readGet;  // capture the indexed entry for a get
    logic wrEntry;  // write current value at current index, emit event
    logic advance;  // next page, next list word, one fewer left
    logic capture;  // take a list word from memory
    logic setErr;   // mark the status as parameter error
  } dpCtrl_t;

  localparam logic STATUS_OK  = 1'b0;
  localparam logic STATUS_ERR = 1'b1;

endpackage

// File: rtl/xlat_cmd_dp.sv
module xlat_cmd_dp
  import xlat_cmd_pkg::*;
#(
  parameter int          ENTRIES    = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_0001_0000,
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int          LIST_MAX   = 512,
  parameter int          CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [1:0]       cmdOp,
  input  logic [63:0]      cmdTableId,
  input  logic [63:0]      cmdBusAddr,
  input  logic [63:0]      cmdArg,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [63:0]      memRdData,
  output opKind_e          opKind,
  output logic             cmdBad,
  output logic             idxBad,
  output logic             lastEntry,
  output logic             doneStatus,
  output logic [63:0]      doneData,
  output logic [63:0]      memAddr,
  output logic             evtValid,
  output logic             evtMap,
  output logic [63:0]      evtIova,
  output logic [63:0]      evtAddr
);
  localparam logic [63:0] PAGE_SIZE = 64'd1 << PAGE_SHIFT;
  localparam logic [63:0] PAGE_MASK = ~(PAGE_SIZE - 64'd1);
  localparam int          IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [1:0]       opReg;
  logic [63:0]      idReg, addrReg, valReg, listPtr, getData;
  logic [CNT_W-1:0] remain;
  logic             statusReg;
  logic [63:0]      entryMem [ENTRIES];

  logic [63:0]      relAddr, fullIdx, memSwapped;
  logic [IDX_W-1:0] idx;
  logic             idBad, fillBad, listBad;

  // big-endian list word: lane 0 carries the most significant byte
  for (genvar k = 0; k < 8; k++) begin : g_swap
    assign memSwapped[8*k +: 8] = memRdData[63-8*k -: 8];
  end

  assign relAddr   = addrReg - BUS_OFFSET;
  assign fullIdx   = relAddr >> PAGE_SHIFT;
  assign idx       = fullIdx[IDX_W-1:0];
  assign idxBad    = fullIdx >= 64'(ENTRIES);
  assign lastEntry = remain == CNT_W'(1);

  assign idBad   = (|idReg[63:32]) || (idReg[31:0] != TABLE_ID);
  assign fillBad = (remain == '0) || (remain > CNT_W'(ENTRIES));
  assign listBad = (remain == '0) || (remain > CNT_W'(LIST_MAX)) || (|listPtr[11:0]);

  always_comb begin
    opKind = opKind_e'(opReg);
    cmdBad = idBad;
    if (opKind == OP_FILL) cmdBad = idBad || fillBad;
    if (opKind == OP_LIST) cmdBad = idBad || listBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg     <= '0;
      idReg     <= '0;
      addrReg   <= '0;
      valReg    <= '0;
      listPtr   <= '0;
      remain    <= '0;
      statusReg <= STATUS_OK;
      getData   <= '0;
    end else begin
      if (ctl.load) begin
        opReg     <= cmdOp;
        idReg     <= cmdTableId;
        addrReg   <= cmdBusAddr & PAGE_MASK;
        valReg    <= cmdArg;
        listPtr   <= cmdArg;
        remain    <= (cmdOp == OP_PUT) ? CNT_W'(1) : cmdCount;
        statusReg <= STATUS_OK;
        getData   <= '0;
      end
      if (ctl.advance) begin
        addrReg <= addrReg + PAGE_SIZE;
        listPtr <= listPtr + 64'd8;
        remain  <= remain - CNT_W'(1);
      end
      if (ctl.capture) valReg    <= memSwapped;
      if (ctl.readGet) getData   <= entryMem[idx];
      if (ctl.setErr)  statusReg <= STATUS_ERR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entryMem[i] <= '0;
      evtValid <= 1'b0;
      evtMap   <= 1'b0;
      evtIova  <= '0;
      evtAddr  <= '0;
    end else begin
      evtValid <= ctl.wrEntry;
      if (ctl.wrEntry) begin
        entryMem[idx] <= valReg;
        evtMap        <= |valReg[1:0];
        evtIova       <= relAddr & PAGE_MASK;
        evtAddr       <= valReg & PAGE_MASK;
      end
    end
  end

  assign doneStatus = statusReg;
  assign doneData   = getData;
  assign memAddr    = listPtr;

endmodule

// File: rtl/xlat_cmd_ctrl.sv
module xlat_cmd_ctrl
  import xlat_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  opKind_e opKind,
  input  logic    cmdBad,
  input  logic    idxBad,
  input  logic    lastEntry,
  input  logic    memRdValid,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    doneValid,
  output logic    memReq
);
  engState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    memReq    = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        ctl.load  = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (cmdBad) begin
          ctl.setErr = 1'b1;
          nextState  = ST_DONE;
        end else if (opKind == OP_GET) begin
          ctl.setErr  = idxBad;
          ctl.readGet = !idxBad;
          nextState   = ST_DONE;
        end else if (opKind == OP_LIST) begin
          nextState = ST_FETCH;
        end else begin
          nextState = ST_STEP;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memRdValid) begin
          ctl.capture = 1'b1;
          nextState   = ST_STEP;
        end
      end
      ST_STEP: begin
        if (idxBad) begin
          ctl.setErr = 1'b1;
          nextState  = ST_DONE;
        end else begin
          ctl.wrEntry = 1'b1;
          if (lastEntry) begin
            nextState = ST_DONE;
          end else begin
            ctl.advance = 1'b1;
            nextState   = (opKind == OP_LIST) ? ST_FETCH : ST_STEP;
          end
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = state != ST_IDLE;

endmodule

// File: rtl/xlat_cmd_engine.sv
module xlat_cmd_engine
  import xlat_cmd_pkg::*;
#(
  parameter int          ENTRIES    = 16,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_0001_0000,
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int          LIST_MAX   = 512,
  parameter int          CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [63:0]      cmdTableId,
  input  logic [63:0]      cmdBusAddr,
  input  logic [63:0]      cmdArg,
  input  logic [CNT_W-1:0] cmdCount,
  output logic             busy,
  output logic             doneValid,
  output logic             doneStatus,
  output logic [63:0]      doneData,
  output logic             memReq,
  output logic [63:0]      memAddr,
  input  logic             memRdValid,
  input  logic [63:0]      memRdData,
  output logic             evtValid,
  output logic             evtMap,
  output logic [63:0]      evtIova,
  output logic [63:0]      evtAddr
);
  dpCtrl_t ctl;
  opKind_e opKind;
  logic    cmdBad, idxBad, lastEntry;

  xlat_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .opKind     (opKind),
    .cmdBad     (cmdBad),
    .idxBad     (idxBad),
    .lastEntry  (lastEntry),
    .memRdValid (memRdValid),
    .ctl        (ctl),
    .busy       (busy),
    .doneValid  (doneValid),
    .memReq     (memReq)
  );

  xlat_cmd_dp #(
    .ENTRIES    (ENTRIES),
    .PAGE_SHIFT (PAGE_SHIFT),
    .BUS_OFFSET (BUS_OFFSET),
    .TABLE_ID   (TABLE_ID),
    .LIST_MAX   (LIST_MAX),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdOp      (cmdOp),
    .cmdTableId (cmdTableId),
    .cmdBusAddr (cmdBusAddr),
    .cmdArg     (cmdArg),
    .cmdCount   (cmdCount),
    .memRdData  (memRdData),
    .opKind     (opKind),
    .cmdBad     (cmdBad),
    .idxBad     (idxBad),
    .lastEntry  (lastEntry),
    .doneStatus (doneStatus),
    .doneData   (doneData),
    .memAddr    (memAddr),
    .evtValid   (evtValid),
    .evtMap     (evtMap),
    .evtIova    (evtIova),
    .evtAddr    (evtAddr)
  );

endmodule

// File: rtl/xlat_cmd_engine_chk.sv
module xlat_cmd_engine_chk #(
  parameter int PAGE_SHIFT = 12
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        busy,
  input logic        doneValid,
  input logic        memReq,
  input logic [63:0] memAddr,
  input logic        memRdValid,
  input logic        evtValid,
  input logic [63:0] evtIova,
  input logic [63:0] evtAddr
);
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !busy); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid)); // R10
  AST_EVT_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> busy); // R8
  AST_EVT_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtIova[PAGE_SHIFT-1:0] == '0) && (evtAddr[PAGE_SHIFT-1:0] == '0)); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> (memReq && $stable(memAddr))); // R6
  AST_MEM_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[2:0] == 3'b000)); // R6
endmodule

bind xlat_cmd_engine xlat_cmd_engine_chk #(.PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .busy       (busy),
  .doneValid  (doneValid),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .evtValid   (evtValid),
  .evtIova    (evtIova),
  .evtAddr    (evtAddr)
);

// File: tb/xlat_cmd_engine_tb.sv
module xlat_cmd_engine_tb;
  localparam logic [63:0] OFF = 64'h1_0000;
  localparam logic [31:0] TID = 32'h8000_0001;
  localparam logic [63:0] PG  = 64'h1000;
  localparam logic [63:0] PM  = ~64'hFFF;
  localparam int          ENT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [63:0] cmdTableId = '0, cmdBusAddr = '0, cmdArg = '0;
  logic [15:0] cmdCount = '0;
  logic busy, doneValid, doneStatus, memReq, evtValid, evtMap;
  logic [63:0] doneData, memAddr, evtIova, evtAddr;
  logic memRdValid = 1'b0;
  logic [63:0] memRdData = '0;

  int nChk = 0, nFail = 0;
  logic [63:0] tm [ENT];
  logic [63:0] listMem [32];
  logic [63:0] listBase = '0;
  logic [63:0] gotIova [64], gotAddr [64];
  logic        gotMap [64];
  int          gotN = 0;

  always #5 clk = ~clk;

  xlat_cmd_engine u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdTableId(cmdTableId), .cmdBusAddr(cmdBusAddr), .cmdArg(cmdArg),
    .cmdCount(cmdCount), .busy(busy), .doneValid(doneValid),
    .doneStatus(doneStatus), .doneData(doneData), .memReq(memReq),
    .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .evtValid(evtValid), .evtMap(evtMap), .evtIova(evtIova), .evtAddr(evtAddr)
  );

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[63-8*k -: 8];
    return r;
  endfunction

  // memory model: answers one cycle after a request is seen
  always @(negedge clk) begin
    memRdValid <= memReq && !memRdValid;
    memRdData  <= bswap(listMem[5'((memAddr - listBase) >> 3)]);
  end

  always @(negedge clk) begin
    if (evtValid && gotN < 64) begin
      gotIova[gotN] = evtIova;
      gotAddr[gotN] = evtAddr;
      gotMap[gotN]  = evtMap;
      gotN++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [63:0] id, input logic [63:0] addr,
                        input logic [63:0] arg, input logic [15:0] cnt, input string tag,
                        input bit intr = 1'b0);
    logic [63:0] masked, rel, v, expD;
    logic [63:0] eIova [64], eAddr [64];
    logic        eMap [64];
    logic        expSt;
    int eN, k, cyc, expCyc, n;
    bit stop;
    masked = addr & PM;
    expSt = 1'b0; expD = '0; eN = 0; k = 0; stop = 1'b0;
    if (id[63:32] != 0 || id[31:0] != TID) expSt = 1'b1;
    else if (op == 2'd1) begin
      rel = masked - OFF;
      if ((rel >> 12) >= 64'(ENT)) expSt = 1'b1;
      else expD = tm[4'(rel >> 12)];
    end else if (op == 2'd2 && (cnt == 0 || cnt > 16'(ENT))) expSt = 1'b1;
    else if (op == 2'd3 && (cnt == 0 || cnt > 16'd512 || arg[11:0] != 0)) expSt = 1'b1;
    else begin
      n = (op == 2'd0) ? 1 : int'(cnt);
      for (int i = 0; i < n && !stop; i++) begin
        rel = masked + 64'(i) * PG - OFF;
        k++;
        if ((rel >> 12) >= 64'(ENT)) begin
          expSt = 1'b1;
          stop = 1'b1;
        end else begin
          v = (op == 2'd3) ? listMem[i % 32] : arg;
          tm[4'(rel >> 12)] = v;
          eIova[eN] = rel & PM; eAddr[eN] = v & PM; eMap[eN] = |v[1:0];
          eN++;
        end
      end
    end
    expCyc = (op == 2'd3) ? 2 + 2 * k : 2 + k;

    listBase = arg;
    gotN = 0;
    @(negedge clk);
    cmdOp = op; cmdTableId = id; cmdBusAddr = addr; cmdArg = arg; cmdCount = cnt;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = intr;
    if (intr) begin
      cmdOp = 2'd0; cmdTableId = {32'd0, TID}; cmdBusAddr = OFF + 10 * PG;
      cmdArg = 64'hDEAD_BEEF_0000_0003;
    end
    cyc = 1;
    while (!doneValid && cyc < 5000) begin
      @(negedge clk);
      cmdValid = 1'b0;
      cyc++;
    end
    #1;
    chk(doneValid, {tag, " completion seen (R10)"}, 64'(doneValid), 64'd1);
    chk(doneStatus == expSt, {tag, " status"}, 64'(doneStatus), 64'(expSt));
    chk(cyc == expCyc, {tag, " latency R10"}, 64'(cyc), 64'(expCyc));
    if (op == 2'd1 && !expSt)
      chk(doneData == expD, {tag, " get data R4"}, doneData, expD);
    chk(gotN == eN, {tag, " event count R8"}, 64'(gotN), 64'(eN));
    for (int i = 0; i < eN && i < gotN; i++) begin
      chk(gotIova[i] == eIova[i], {tag, " event iova R8"}, gotIova[i], eIova[i]);
      chk(gotAddr[i] == eAddr[i], {tag, " event addr R8"}, gotAddr[i], eAddr[i]);
      chk(gotMap[i] == eMap[i], {tag, " event map R8"}, 64'(gotMap[i]), 64'(eMap[i]));
    end
  endtask

  task automatic readAll(input string tag);
    for (int p = 0; p < ENT; p++) runCmd(2'd1, {32'd0, TID}, OFF + 64'(p) * PG, '0, '0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] gid;
    gid = {32'd0, TID};
    void'($urandom(32'd1234));
    for (int i = 0; i < ENT; i++) tm[i] = '0;
    for (int i = 0; i < 32; i++) listMem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !evtValid && !memReq, "R9 idle outputs after reset",
        {60'd0, busy, doneValid, evtValid, memReq}, 64'd0);
    rstN = 1'b1;
    readAll("R9 cleared table");

    // directed corners
    runCmd(2'd0, gid, OFF + 3 * PG + 64'h123, 64'h0000_0000_ABCD_E003, 16'd77, "R3 put");
    runCmd(2'd1, gid, OFF + 3 * PG + 64'hFFF, '0, '0, "R2 get masked addr");
    runCmd(2'd0, {32'h1, TID}, OFF, 64'h5, '0, "R1 upper id bits");
    runCmd(2'd0, {32'd0, TID ^ 32'h1}, OFF, 64'h5, '0, "R1 id mismatch");
    runCmd(2'd0, gid, OFF - PG, 64'h7, '0, "R2 below base");
    runCmd(2'd0, gid, OFF + 16 * PG, 64'h7, '0, "R2 past end");
    runCmd(2'd1, gid, OFF + 16 * PG, '0, '0, "R2 get past end");
    runCmd(2'd0, gid, OFF + 5 * PG, 64'h0000_0000_1234_5000, '0, "R8 unmap put");
    runCmd(2'd2, gid, OFF, 64'h11, 16'd0, "R5 fill zero");
    runCmd(2'd2, gid, OFF, 64'h11, 16'd17, "R5 fill too long");
    runCmd(2'd2, gid, OFF, 64'h0000_0000_7777_7001, 16'd16, "R5 fill full");
    runCmd(2'd2, gid, OFF + 14 * PG, 64'h0000_0000_8888_8002, 16'd4, "R7 fill overrun");
    runCmd(2'd3, gid, OFF, 64'h20_0000, 16'd513, "R6 list too long");
    runCmd(2'd3, gid, OFF, 64'h20_0008, 16'd2, "R6 list unaligned");
    runCmd(2'd3, gid, OFF, 64'h20_0000, 16'd0, "R6 list zero");
    listMem[0] = 64'h0102_0304_0506_0703;
    runCmd(2'd3, gid, OFF + 2 * PG, 64'h20_0000, 16'd3, "R6 list put");
    runCmd(2'd1, gid, OFF + 2 * PG, '0, '0, "R6 big-endian readback");
    runCmd(2'd3, gid, OFF + 15 * PG, 64'h30_0000, 16'd3, "R7 list overrun");
    runCmd(2'd3, gid, OFF, 64'h40_0000, 16'd512, "R6 list max count");
    readAll("R7 table after overruns");

    // command while busy is ignored
    runCmd(2'd2, gid, OFF, 64'h0000_0000_4444_4003, 16'd4, "R10 fill with intrusion", 1'b1);
    @(negedge clk);
    chk(!busy, "R10 busy low after done", 64'(busy), 64'd0);
    runCmd(2'd1, gid, OFF + 10 * PG, '0, '0, "R10 ignored put left entry");

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [1:0] op;
      logic [63:0] id, addr, arg;
      logic [15:0] cnt;
      string tag;
      op   = 2'($urandom_range(0, 3));
      id   = ($urandom_range(0, 9) == 0) ? {32'd0, $urandom} : gid;
      addr = OFF - 2 * PG + 64'($urandom_range(0, 20)) * PG + 64'($urandom_range(0, 4095));
      arg  = {$urandom, $urandom};
      cnt  = 16'($urandom_range(0, 18));
      if (op == 2'd3) begin
        arg = ($urandom_range(0, 7) == 0) ? 64'h50_0000 + 64'($urandom_range(1, 4095))
                                          : 64'h50_0000;
        cnt = 16'($urandom_range(0, 6));
        for (int i = 0; i < 32; i++) listMem[i] = {$urandom, $urandom};
      end
      case (op)
        2'd0: tag = "R3 random put";
        2'd1: tag = "R4 random get";
        2'd2: tag = "R5 random fill";
        default: tag = "R6 random list";
      endcase
      runCmd(op, id, addr, arg, cnt, tag);
    end
    readAll("R4 final readback");

    // reset in the middle of use
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < ENT; i++) tm[i] = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readAll("R9 reset clears entries");

    summary();
    $finish;
  end
endmodule